// File: doc/BRIEF.md
# Always-On Wakeup Interrupt Controller

This block collects up to 32 interrupt lines in an always-on domain and turns them into one wake request for a power-management coprocessor. Line 0 comes from an external NMI pin, and software picks its trigger type: low level, high level, rising edge or falling edge. Lines 1 and up are level lines that also run directly to the main interrupt distributor. This block only observes those lines.

The block has two output paths. The NMI copy sent to the main distributor is gated only by enable bit 0. The coprocessor request combines every enabled pending line that is neither masked nor marked in service. A vector register tells the coprocessor which line to serve first: the lowest-numbered qualifying line wins. All registers are reached over a simple bus with an address, a write strobe, write data and combinational read data.

Top module: `wake_intc`

## Requirements
- R1: After reset the base, NMI control, enable, mask and response registers read 0, and both `nmi_dist_o` and `cop_irq_o` are low.
- R2: A pending bit for lines 1 and up follows its input after a two-flop synchroniser, appearing within 3 clock edges. Writes to the pending register leave these bits unchanged.
- R3: In NMI control mode 0 (low level) pending bit 0 is the inverted synchronised pin. In mode 3 (high level) it is the synchronised pin. A write of 1 to pending bit 0 has no effect in either mode.
- R4: In NMI control mode 2 (rising edge) or mode 1 (falling edge), the matching pin transition sets pending bit 0 within 4 clock edges. The bit stays set after the pin returns, and it clears only when 1 is written to bit 0 at the pending offset.
- R5: `nmi_dist_o` equals pending bit 0 AND enable bit 0. Enable bits 1 and up never change it.
- R6: `cop_irq_o` is high exactly when some line is pending and enabled, and also clear in both the mask and the response register. Writing 1 to a response bit blocks that line until software writes the bit back to 0.
- R7: The vector register reads base plus 4 times the index of the lowest-numbered line that qualifies under R6. It reads base alone when no line qualifies.
- R8: Register offsets (byte address):
  - vector 0x00, read-only;
  - base 0x04;
  - NMI control 0x0C, bits [1:0];
  - pending 0x10;
  - enable 0x40;
  - mask 0x50;
  - response 0x60.
  Written values read back at the same offset, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_pin_i | input | 1 | External NMI pin, asynchronous |
| irq_i | input | NUM_IN-1 | Level lines 1..NUM_IN-1, asynchronous |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| nmi_dist_o | output | 1 | Gated NMI level to the main distributor |
| cop_irq_o | output | 1 | Combined wake request to the coprocessor |

## Verification
A corrupted enable, mask or response bit shows at `cop_irq_o` and at the vector read in the same cycle it is wrong, provided the matching line is pending. A lost or stuck NMI edge latch shows at `nmi_dist_o` at once, because that output is a plain AND of two flops. A wrong synchroniser depth shifts the level-line pending bits by a cycle, so the bench samples only after the settle window and also reads the pending word back. A spurious edge detection on a mode change shows as pending bit 0 set without any pin transition.

// File: rtl/wic_pkg.sv
package wic_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFF_VEC  = 8'h00;
  localparam logic [7:0] OFF_BASE = 8'h04;
  localparam logic [7:0] OFF_CTRL = 8'h0C;
  localparam logic [7:0] OFF_PEND = 8'h10;
  localparam logic [7:0] OFF_EN   = 8'h40;
  localparam logic [7:0] OFF_MASK = 8'h50;
  localparam logic [7:0] OFF_RESP = 8'h60;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_e;
endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/wic_nmi_detect.sv
module wic_nmi_detect
  import wic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,   // already synchronised
  input  trig_e mode_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic prev_q, latch_q;
  logic edge_mode, hit;

  assign edge_mode = (mode_i == TRIG_RISE) || (mode_i == TRIG_FALL);
  assign hit = (mode_i == TRIG_RISE) ? (pin_i & ~prev_q) :
               (mode_i == TRIG_FALL) ? (~pin_i & prev_q) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      // a new edge wins over a simultaneous clear
      if (!edge_mode)  latch_q <= 1'b0;
      else if (hit)    latch_q <= 1'b1;
      else if (clr_i)  latch_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode_i)
      TRIG_HIGH: pend_o = pin_i;
      TRIG_LOW:  pend_o = ~pin_i;
      default:   pend_o = latch_q;
    endcase
  end

  a_r4_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && hit && $stable(mode_i)) |=> latch_q);
  a_r4_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && latch_q && !clr_i && $stable(mode_i)) |=> latch_q);
endmodule

// File: rtl/wic_lowest.sv
module wic_lowest #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wic_regs.sv
module wic_regs
  import wic_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [N-1:0]      pend_i,
  input  logic [REG_W-1:0]  vector_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  base_o,
  output trig_e             mode_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      resp_o,
  output logic              nmi_clr_o
);
  logic [7:0] off;
  assign off = 8'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      mode_o <= TRIG_LOW;
      en_o   <= '0;
      mask_o <= '0;
      resp_o <= '0;
    end else if (wr_en_i) begin
      case (off)
        OFF_BASE: base_o <= wdata_i;
        OFF_CTRL: mode_o <= trig_e'(wdata_i[1:0]);
        OFF_EN:   en_o   <= wdata_i[N-1:0];
        OFF_MASK: mask_o <= wdata_i[N-1:0];
        OFF_RESP: resp_o <= wdata_i[N-1:0];
        default: ;
      endcase
    end
  end

  assign nmi_clr_o = wr_en_i && (off == OFF_PEND) && wdata_i[0];

  always_comb begin
    case (off)
      OFF_VEC:  rdata_o = vector_i;
      OFF_BASE: rdata_o = base_o;
      OFF_CTRL: rdata_o = REG_W'(mode_o);
      OFF_PEND: rdata_o = REG_W'(pend_i);
      OFF_EN:   rdata_o = REG_W'(en_o);
      OFF_MASK: rdata_o = REG_W'(mask_o);
      OFF_RESP: rdata_o = REG_W'(resp_o);
      default:  rdata_o = '0;
    endcase
  end

  a_r8_base_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off == OFF_BASE) |=> (base_o == $past(wdata_i)));
  a_r8_resp_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off == OFF_RESP) |=> (resp_o == $past(wdata_i[N-1:0])));
  a_r6_resp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && off == OFF_RESP) |=> $stable(resp_o));
endmodule

// File: rtl/wake_intc.sv
module wake_intc
  import wic_pkg::*;
#(
  parameter int unsigned NUM_IN = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_pin_i,
  input  logic [NUM_IN-1:1] irq_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              nmi_dist_o,
  output logic              cop_irq_o
);
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [NUM_IN-1:0] raw_s;
  logic [NUM_IN-1:0] pending, active, en, mask, resp;
  logic [31:0]       base, vector;
  trig_e             mode;
  logic              nmi_pend, nmi_clr, any_active;
  logic [IDX_W-1:0]  win_idx;

  wic_sync #(.W(NUM_IN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({irq_i, nmi_pin_i}),
    .q_o   (raw_s)
  );

  wic_nmi_detect u_nmi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (raw_s[0]),
    .mode_i(mode),
    .clr_i (nmi_clr),
    .pend_o(nmi_pend)
  );

  assign pending = {raw_s[NUM_IN-1:1], nmi_pend};
  assign active  = pending & en & ~mask & ~resp;

  wic_lowest #(.N(NUM_IN), .IDX_W(IDX_W)) u_low (
    .vec_i  (active),
    .found_o(any_active),
    .idx_o  (win_idx)
  );

  assign vector = any_active ? (base + (32'(win_idx) << 2)) : base;

  wic_regs #(.N(NUM_IN), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .pend_i   (pending),
    .vector_i (vector),
    .rdata_o  (rdata_o),
    .base_o   (base),
    .mode_o   (mode),
    .en_o     (en),
    .mask_o   (mask),
    .resp_o   (resp),
    .nmi_clr_o(nmi_clr)
  );

  // only enable bit 0 reaches the distributor path
  assign nmi_dist_o = nmi_pend & en[0];
  assign cop_irq_o  = any_active;

  a_r5_nmi_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_dist_o |-> en[0]);
  a_r6_cop_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_irq_o |-> |(pending & en & ~resp));
  a_r7_idx_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_active |-> active[win_idx]);
  a_r7_idx_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_active |-> ((active & ((NUM_IN'(1) << win_idx) - NUM_IN'(1))) == '0));
endmodule

// File: tb/sim_wake_intc.sv
`timescale 1ns/1ps
module sim_wake_intc;
  localparam int N = 32;
  localparam logic [7:0] A_VEC = 8'h00, A_BASE = 8'h04, A_CTRL = 8'h0C,
    A_PEND = 8'h10, A_EN = 8'h40, A_MASK = 8'h50, A_RESP = 8'h60;

  logic clk = 0, rst_n = 0, nmi = 0, wr = 0;
  logic [N-1:1] irq = '0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic nmi_dist, cop;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wake_intc #(.NUM_IN(N), .ADDR_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .nmi_pin_i(nmi), .irq_i(irq),
    .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .nmi_dist_o(nmi_dist), .cop_irq_o(cop));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; wr = 0; #1 d = rdata;
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  function automatic logic [31:0] exp_vec(logic [31:0] b, logic [31:0] act);
    for (int i = 0; i < N; i++) if (act[i]) return b + 32'(i) * 4;
    return b;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, en, mk, rs, bs, pend, act;
    logic [1:0] md;
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 nmi_dist", 32'(nmi_dist), 0);
    check("R1 cop", 32'(cop), 0);
    rreg(A_BASE, v); check("R1 base", v, 0);
    rreg(A_CTRL, v); check("R1 ctrl", v, 0);
    rreg(A_EN, v);   check("R1 en", v, 0);
    rreg(A_MASK, v); check("R1 mask", v, 0);
    rreg(A_RESP, v); check("R1 resp", v, 0);
    // R8 map and unmapped offsets
    wreg(A_BASE, 32'h0000_1200); rreg(A_BASE, v); check("R8 base rb", v, 32'h1200);
    rreg(8'h08, v); check("R8 unmapped 08", v, 0);
    rreg(8'h44, v); check("R8 unmapped 44", v, 0);
    wreg(A_MASK, 32'hA5A5_0000); rreg(A_MASK, v); check("R8 mask rb", v, 32'hA5A5_0000);
    wreg(A_MASK, 0);
    // R3 level low: pin low -> pending0 set, W1C ignored
    settle();
    rreg(A_PEND, v); check("R3 low-level pin low", 32'(v[0]), 1);
    wreg(A_PEND, 32'h1); rreg(A_PEND, v); check("R3 w1c ignored", 32'(v[0]), 1);
    // R5 enable bits 1+ do not drive nmi_dist
    wreg(A_EN, 32'hFFFF_FFFE); #1 check("R5 upper enables", 32'(nmi_dist), 0);
    wreg(A_EN, 32'h1); #1 check("R5 en0 gates", 32'(nmi_dist), 1);
    wreg(A_CTRL, 32'h3); settle(); check("R3 high-level pin low", 32'(nmi_dist), 0);
    // R4 rising edge
    wreg(A_CTRL, 32'h2); settle();
    rreg(A_PEND, v); check("R4 rise no edge", 32'(v[0]), 0);
    @(negedge clk); nmi = 1; settle();
    check("R4 rise latched", 32'(nmi_dist), 1);
    @(negedge clk); nmi = 0; settle();
    check("R4 rise held", 32'(nmi_dist), 1);
    wreg(A_PEND, 32'h1); settle(); check("R4 rise w1c", 32'(nmi_dist), 0);
    // R4 falling edge
    wreg(A_CTRL, 32'h1);
    @(negedge clk); nmi = 1; settle();
    check("R4 fall ignores rise", 32'(nmi_dist), 0);
    @(negedge clk); nmi = 0; settle();
    check("R4 fall latched", 32'(nmi_dist), 1);
    wreg(A_PEND, 32'h0); settle(); check("R4 write0 no clear", 32'(nmi_dist), 1);
    wreg(A_PEND, 32'h1); settle(); check("R4 fall w1c", 32'(nmi_dist), 0);
    // R6/R7 response and mask blocking
    wreg(A_CTRL, 32'h3); wreg(A_EN, 32'h20);
    @(negedge clk); irq[5] = 1; settle();
    check("R6 cop on", 32'(cop), 1);
    rreg(A_VEC, v); check("R7 vec idx5", v, 32'h1200 + 20);
    wreg(A_RESP, 32'h20); #1 check("R6 resp blocks", 32'(cop), 0);
    rreg(A_VEC, v); check("R7 vec none", v, 32'h1200);
    settle(); check("R6 resp holds", 32'(cop), 1'b0);
    wreg(A_RESP, 0); #1 check("R6 resp cleared", 32'(cop), 1);
    wreg(A_MASK, 32'h20); #1 check("R6 mask blocks", 32'(cop), 0);
    wreg(A_MASK, 0);
    // R2 level follows input
    @(negedge clk); irq[5] = 0; settle();
    check("R2 level drop", 32'(cop), 0);
    // random mix with level NMI modes
    for (int it = 0; it < 60; it++) begin
      en = $urandom(); mk = $urandom(); rs = $urandom() & $urandom();
      bs = $urandom() & 32'hFFFF_FFF0;
      md = ($urandom() & 1) ? 2'b11 : 2'b00;
      wreg(A_EN, en); wreg(A_MASK, mk); wreg(A_RESP, rs);
      wreg(A_BASE, bs); wreg(A_CTRL, 32'(md));
      @(negedge clk);
      irq = (N-1)'($urandom() & $urandom() & $urandom());
      nmi = 1'($urandom());
      settle();
      wreg(A_PEND, $urandom());
      pend = {irq, (md == 2'b11) ? nmi : ~nmi};
      act = pend & en & ~mk & ~rs;
      rreg(A_PEND, v); check("R2 R3 pending", v, pend);
      check("R6 cop random", 32'(cop), 32'(act != 0));
      check("R5 nmi_dist random", 32'(nmi_dist), 32'(pend[0] & en[0]));
      rreg(A_VEC, v); check("R7 vec random", v, exp_vec(bs, act));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule